// File: doc/BRIEF.md
# Looping Address Generator Datapath

This block produces one 16-bit memory address per clock and updates the pointer that produced it in the same cycle. Four register files hold its state: sixteen address pointers, six offsets split into two banks of three, four compare bounds and four initialization values. Compare bound k and initialization value k are used together as one pair. An operation code, applied with its field selects, picks a pointer (or external data in its place) and an offset. The block then drives an address and changes the pointer in place by increment, decrement, add, subtract, a bitwise operation or a one-bit shift.

Looping operations compare the driven address with the selected bound. The direction of the test follows the direction of the step. When the bound is reached and the pair's mask bit is set, the pointer is reloaded from the paired initialization value. This gives loop wraparound without spending an extra cycle. A mode input chooses whether the address shows the pointer before or after its update, and a second input can reverse the bit order of the driven address. The block is controlled by a decoded operation stream and has no sequencing of its own.

Top module: `loop_addr_gen`

## Requirements
- R1: A synchronous active-high `rst` clears every pointer, offset, bound and initialization value, and clears `addr_out` and `flag_out` to 0.
- R2: The offset operand is chosen by `ofs_sel` and `ofs_bank`. Codes 0..2 select stored offset `ofs_bank*3 + ofs_sel`. Code 3 in either bank uses `data_in` in place of a stored offset, and a load with code 3 changes no stored offset.
- R3: The compare flag is an unsigned test of the driven address against bound `pair_sel`. It is set on increment (1) or add (3) when the address is >= the bound, and on decrement (2) or subtract (4) when the address is <= the bound.
- R4: The value compared with the bound is always the value driven on the address output, so in post-update mode it is the updated value.
- R5: With `post_mode`=0 the address output shows the source before the update. With `post_mode`=1 it shows the update result. In both modes the result is written back.
- R6: The result is written to pointer `ptr_sel` even when `ext_src`=1 selects `data_in` as the source.
- R7: Left shift (8) shifts in a zero. Right shift (9) keeps bit 15.
- R8: When a looping operation (codes 1..4) sets the compare flag and `reinit_mask[pair_sel]` is 1, the pointer is loaded with initialization value `pair_sel` instead of the result.
- R9: With `rev_en`=1, bit i of the address output is bit 15-i of the driven value. The written-back value is not reversed.
- R10: The zero flag is set when a bitwise operation (AND 5, OR 6, XOR 7) or a shift gives 0. `flag_out` shows the compare flag for looping operations and the zero flag for bitwise and shift operations. It is 0 after any other operation.
- R11: `addr_out` and `flag_out` are registered and show the result one clock after the operation is applied. Operations other than codes 1..9 leave `addr_out` unchanged.
- R12: Load codes write `data_in`: 10 to pointer `ptr_sel`, 11 to the selected offset, 12 to bound `pair_sel`, 13 to initialization value `pair_sel`. Code 0 is no operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| ptr_sel | input | 4 | Pointer index |
| ofs_sel | input | 2 | Offset code within the bank (3 = external data) |
| pair_sel | input | 2 | Compare/initialization pair index |
| ext_src | input | 1 | Use data_in as the source in place of the pointer |
| data_in | input | 16 | External data and load value |
| post_mode | input | 1 | 1 = drive the updated value |
| rev_en | input | 1 | Reverse the bit order of the address output |
| ofs_bank | input | 1 | Offset bank select |
| reinit_mask | input | 4 | Per-pair reload enable |
| addr_out | output | 16 | Registered address |
| flag_out | output | 1 | Registered compare/zero flag |

## Verification
Every result of an operation appears exactly one clock edge after the operation is applied. This holds for both the address and the flag. Register-file writes made by an operation first show up on the address output of the next operation that reads them. The driver applies one operation per falling edge and pushes the address and flag predicted for it. The monitor pops that prediction one nanosecond after the following rising edge, so each comparison falls in the cycle where the registered outputs have just changed. Effects that are only written back, such as reloads, external-source writeback and the unreversed stored value, are checked by a later pre-update increment of the same pointer.

// File: rtl/lag_pkg.sv
package lag_pkg;
  typedef enum logic [3:0] {
    OP_NOP = 4'd0,  OP_INC = 4'd1,  OP_DEC = 4'd2,  OP_ADD = 4'd3,
    OP_SUB = 4'd4,  OP_AND = 4'd5,  OP_OR  = 4'd6,  OP_XOR = 4'd7,
    OP_SHL = 4'd8,  OP_SHR = 4'd9,  OP_LDR = 4'd10, OP_LDB = 4'd11,
    OP_LDC = 4'd12, OP_LDI = 4'd13
  } lag_op_e;

  function automatic logic op_is_loop(lag_op_e o);
    return o inside {OP_INC, OP_DEC, OP_ADD, OP_SUB};
  endfunction

  function automatic logic op_is_down(lag_op_e o);
    return (o == OP_DEC) || (o == OP_SUB);
  endfunction

  function automatic logic op_is_logic(lag_op_e o);
    return o inside {OP_AND, OP_OR, OP_XOR, OP_SHL, OP_SHR};
  endfunction
endpackage

// File: rtl/lag_regfile.sv
module lag_regfile #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [IW-1:0] idx,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  localparam logic [IW:0] LIMIT = (IW+1)'(DEPTH);

  logic [W-1:0] mem [DEPTH];
  logic         in_range;

  assign in_range = {1'b0, idx} < LIMIT;
  assign rdata    = in_range ? mem[idx] : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (we && in_range) begin
      mem[idx] <= wdata;
    end
  end
endmodule

// File: rtl/lag_alu.sv
module lag_alu
  import lag_pkg::*;
#(
  parameter int W = 16
) (
  input  lag_op_e      op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] ofs,
  input  logic [W-1:0] bound,
  input  logic         post,
  output logic [W-1:0] res,
  output logic [W-1:0] out_val,
  output logic         cmp_hit,
  output logic         zero_hit
);
  function automatic logic [W-1:0] calc(lag_op_e o, logic [W-1:0] a, logic [W-1:0] b);
    case (o)
      OP_INC:  return a + W'(1);
      OP_DEC:  return a - W'(1);
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_AND:  return a & b;
      OP_OR:   return a | b;
      OP_XOR:  return a ^ b;
      OP_SHL:  return {a[W-2:0], 1'b0};
      OP_SHR:  return {a[W-1], a[W-1:1]};
      default: return a;
    endcase
  endfunction

  function automatic logic reached(logic down, logic [W-1:0] v, logic [W-1:0] c);
    return down ? (v <= c) : (v >= c);
  endfunction

  always_comb begin
    res      = calc(op, src, ofs);
    out_val  = post ? res : src;
    cmp_hit  = op_is_loop(op) && reached(op_is_down(op), out_val, bound);
    zero_hit = op_is_logic(op) && (res == '0);
  end
endmodule

// File: rtl/lag_bitrev.sv
module lag_bitrev #(
  parameter int W = 16
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = en ? din[W-1-i] : din[i];
  end
endmodule

// File: rtl/loop_addr_gen.sv
module loop_addr_gen
  import lag_pkg::*;
#(
  parameter int W        = 16,
  parameter int NPTR     = 16,
  parameter int NOFS_BNK = 3,
  parameter int NPAIR    = 4,
  localparam int PIW     = $clog2(NPTR),
  localparam int OIW     = $clog2(2 * NOFS_BNK),
  localparam int CIW     = $clog2(NPAIR)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       op,
  input  logic [PIW-1:0]   ptr_sel,
  input  logic [1:0]       ofs_sel,
  input  logic [CIW-1:0]   pair_sel,
  input  logic             ext_src,
  input  logic [W-1:0]     data_in,
  input  logic             post_mode,
  input  logic             rev_en,
  input  logic             ofs_bank,
  input  logic [NPAIR-1:0] reinit_mask,
  output logic [W-1:0]     addr_out,
  output logic             flag_out
);
  localparam logic [1:0] EXT_CODE = 2'd3;

  lag_op_e        op_e;
  logic [W-1:0]   r_rd, b_rd, c_rd, i_rd, r_wd;
  logic [W-1:0]   src, ofs_val, res, out_val, rev_val;
  logic [OIW-1:0] ofs_idx;
  logic           loop_w, down_w, upd_w, ofs_ext;
  logic           cmp_hit, zero_hit, reinit_w;
  logic           r_we, b_we, c_we, i_we;
  logic [W-1:0]   addr_q;
  logic           flag_q;

  assign op_e    = lag_op_e'(op);
  assign loop_w  = op_is_loop(op_e);
  assign down_w  = op_is_down(op_e);
  assign upd_w   = loop_w || op_is_logic(op_e);
  assign ofs_ext = (ofs_sel == EXT_CODE);
  assign ofs_idx = OIW'(ofs_sel) + (ofs_bank ? OIW'(NOFS_BNK) : OIW'(0));

  assign src     = ext_src ? data_in : r_rd;
  assign ofs_val = ofs_ext ? data_in : b_rd;

  // loop wraparound event: bound reached and the pair's reload is enabled
  assign reinit_w = cmp_hit && reinit_mask[pair_sel];

  assign r_we = upd_w || (op_e == OP_LDR);
  assign r_wd = (op_e == OP_LDR) ? data_in : (reinit_w ? i_rd : res);
  assign b_we = (op_e == OP_LDB) && !ofs_ext;
  assign c_we = (op_e == OP_LDC);
  assign i_we = (op_e == OP_LDI);

  lag_regfile #(.W(W), .DEPTH(NPTR)) u_ptr (
    .clk(clk), .rst(rst), .we(r_we), .idx(ptr_sel), .wdata(r_wd), .rdata(r_rd));
  lag_regfile #(.W(W), .DEPTH(2 * NOFS_BNK)) u_ofs (
    .clk(clk), .rst(rst), .we(b_we), .idx(ofs_idx), .wdata(data_in), .rdata(b_rd));
  lag_regfile #(.W(W), .DEPTH(NPAIR)) u_bound (
    .clk(clk), .rst(rst), .we(c_we), .idx(pair_sel), .wdata(data_in), .rdata(c_rd));
  lag_regfile #(.W(W), .DEPTH(NPAIR)) u_init (
    .clk(clk), .rst(rst), .we(i_we), .idx(pair_sel), .wdata(data_in), .rdata(i_rd));

  lag_alu #(.W(W)) u_alu (
    .op(op_e), .src(src), .ofs(ofs_val), .bound(c_rd), .post(post_mode),
    .res(res), .out_val(out_val), .cmp_hit(cmp_hit), .zero_hit(zero_hit));

  lag_bitrev #(.W(W)) u_rev (.en(rev_en), .din(out_val), .dout(rev_val));

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      flag_q <= 1'b0;
    end else begin
      flag_q <= cmp_hit || zero_hit;
      if (upd_w) addr_q <= rev_val;
    end
  end

  assign addr_out = addr_q;
  assign flag_out = flag_q;

  assert_pre_shows_source_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_w && !post_mode && !rev_en) |=> (addr_out == $past(src)));

  assert_post_shows_result_R5: assert property (@(posedge clk) disable iff (rst)
    (upd_w && post_mode && !rev_en) |=> (addr_out == $past(res)));

  assert_up_bound_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (loop_w && !down_w && (out_val >= c_rd)) |=> flag_out);

  assert_down_bound_sets_flag_R3: assert property (@(posedge clk) disable iff (rst)
    (loop_w && down_w && (out_val <= c_rd)) |=> flag_out);

  assert_flag_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !upd_w |=> !flag_out);

  assert_rev_ends_swap_R9: assert property (@(posedge clk) disable iff (rst)
    (upd_w && rev_en) |=>
      ((addr_out[0] == $past(out_val[W-1])) && (addr_out[W-1] == $past(out_val[0]))));

  assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !upd_w |=> $stable(addr_out));
endmodule

// File: tb/loop_addr_gen_tb_top.sv
`timescale 1ns/1ps
module loop_addr_gen_tb_top;
  localparam logic [3:0] NOP = 0, INC = 1, DEC = 2, ADD = 3, SUB = 4, AND_ = 5,
                         OR_ = 6, XOR_ = 7, SHL = 8, SHR = 9, LDR = 10, LDB = 11,
                         LDC = 12, LDI = 13;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  op = 0;
  logic [3:0]  ptr_sel = 0;
  logic [1:0]  ofs_sel = 0;
  logic [1:0]  pair_sel = 0;
  logic        ext_src = 0;
  logic [15:0] data_in = 0;
  logic        post_mode = 0;
  logic        rev_en = 0;
  logic        ofs_bank = 0;
  logic [3:0]  reinit_mask = 0;
  logic [15:0] addr_out;
  logic        flag_out;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [15:0] q_addr[$];
  logic        q_flag[$];
  string       q_tag[$];

  logic [15:0] m_ptr [16];
  logic [15:0] m_ofs [6];
  logic [15:0] m_bnd [4];
  logic [15:0] m_ini [4];
  logic [15:0] m_addr;

  always #4 clk = ~clk;

  loop_addr_gen dut_i (
    .clk(clk), .rst(rst), .op(op), .ptr_sel(ptr_sel), .ofs_sel(ofs_sel),
    .pair_sel(pair_sel), .ext_src(ext_src), .data_in(data_in),
    .post_mode(post_mode), .rev_en(rev_en), .ofs_bank(ofs_bank),
    .reinit_mask(reinit_mask), .addr_out(addr_out), .flag_out(flag_out));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mirror(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[15-i] = v[i];
    return r;
  endfunction

  // driver: applies one operation and predicts its outputs
  task automatic step(input logic [3:0] o, input int p, input int oc, input int pr,
                      input bit ext, input logic [15:0] d, input bit post,
                      input bit rev, input bit bank, input logic [3:0] mask,
                      input string tag);
    logic [15:0] s, b, r, shown;
    bit looping, down, bitwise, hit;
    int bi;
    @(negedge clk);
    op = o; ptr_sel = 4'(p); ofs_sel = 2'(oc); pair_sel = 2'(pr); ext_src = ext;
    data_in = d; post_mode = post; rev_en = rev; ofs_bank = bank; reinit_mask = mask;
    bi = oc + (bank ? 3 : 0);
    s = ext ? d : m_ptr[p];
    b = (oc == 3) ? d : m_ofs[bi];
    case (o)
      INC: r = s + 1;        DEC: r = s - 1;
      ADD: r = s + b;        SUB: r = s - b;
      AND_: r = s & b;       OR_: r = s | b;
      XOR_: r = s ^ b;       SHL: r = s << 1;
      SHR: r = $unsigned($signed(s) >>> 1);
      default: r = s;
    endcase
    looping = (o >= INC) && (o <= SUB);
    bitwise = (o >= AND_) && (o <= SHR);
    down    = (o == DEC) || (o == SUB);
    shown   = post ? r : s;
    hit = 0;
    if (looping) hit = down ? (shown <= m_bnd[pr]) : (shown >= m_bnd[pr]);
    if (bitwise) hit = (r == 16'h0);
    if (looping || bitwise) begin
      m_ptr[p] = (looping && hit && mask[pr]) ? m_ini[pr] : r;
      m_addr = rev ? mirror(shown) : shown;
    end
    if (o == LDR) m_ptr[p] = d;
    if (o == LDB && oc != 3) m_ofs[bi] = d;
    if (o == LDC) m_bnd[pr] = d;
    if (o == LDI) m_ini[pr] = d;
    q_addr.push_back(m_addr);
    q_flag.push_back(hit);
    q_tag.push_back(tag);
  endtask

  // monitor: compares once the registered outputs have settled
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q_addr.size() > 0) begin
        string t;
        t = q_tag.pop_front();
        chk({t, " addr"}, addr_out, q_addr.pop_front());
        chk({t, " flag"}, {15'h0, flag_out}, {15'h0, q_flag.pop_front()});
      end
    end
  end

  initial begin
    #(8 * 20000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m_ptr[i] = 0;
    for (int i = 0; i < 6; i++) m_ofs[i] = 0;
    for (int i = 0; i < 4; i++) begin m_bnd[i] = 0; m_ini[i] = 0; end
    m_addr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 reset addr", addr_out, 16'h0);
    chk("R1 reset flag", {15'h0, flag_out}, 16'h0);
    // R1: cleared pointer and bound; R3 0 >= 0 sets flag
    step(INC, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R1 cleared pointer");
    // R12 loads
    step(LDR, 1, 0, 0, 0, 16'd100, 0, 0, 0, 0, "R12 load ptr1");
    step(LDR, 2, 0, 0, 0, 16'h8005, 0, 0, 0, 0, "R12 load ptr2");
    step(LDB, 0, 0, 0, 0, 16'd5, 0, 0, 0, 0, "R12 load ofs bank0");
    step(LDB, 0, 1, 0, 0, 16'd7, 0, 0, 1, 0, "R12 load ofs bank1");
    step(LDB, 0, 3, 0, 0, 16'h1234, 0, 0, 0, 0, "R2 code3 load ignored");
    step(LDC, 0, 0, 0, 0, 16'd104, 0, 0, 0, 0, "R12 load bound0");
    step(LDI, 0, 0, 0, 0, 16'd90, 0, 0, 0, 0, "R12 load init0");
    step(LDC, 0, 0, 1, 0, 16'd50, 0, 0, 0, 0, "R12 load bound1");
    step(LDI, 0, 0, 1, 0, 16'd200, 0, 0, 0, 0, "R12 load init1");
    step(ADD, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R3 add below bound");
    step(ADD, 1, 1, 0, 0, 0, 0, 0, 1, 0, "R2 bank1 add reaches bound");
    step(INC, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 no reload when masked off");
    step(ADD, 1, 0, 0, 0, 0, 0, 0, 0, 4'b0001, "R8 reload fires");
    step(INC, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R8 pointer reloaded");
    step(SUB, 1, 3, 1, 0, 16'd10, 0, 0, 0, 4'b0001, "R2 external offset");
    step(DEC, 1, 0, 1, 0, 0, 1, 0, 0, 0, "R5 post decrement");
    step(SUB, 1, 0, 1, 1, 16'd60, 1, 0, 0, 0, "R6 external source");
    step(SUB, 1, 0, 1, 0, 0, 1, 0, 0, 0, "R4 post value compared");
    step(DEC, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R3 down bound equal");
    step(INC, 1, 0, 1, 0, 0, 0, 0, 0, 0, "R11 pointer after dec");
    step(SHR, 2, 0, 0, 0, 0, 0, 0, 0, 0, "R7 right shift");
    step(SHL, 2, 0, 0, 0, 0, 1, 0, 0, 0, "R7 left shift post");
    step(AND_, 2, 3, 0, 0, 16'h0, 1, 0, 0, 0, "R10 zero result");
    step(LDR, 3, 0, 0, 0, 16'h00F1, 0, 0, 0, 0, "R12 load ptr3");
    step(OR_, 3, 0, 0, 0, 0, 1, 0, 0, 0, "R10 or nonzero");
    step(XOR_, 3, 0, 0, 0, 0, 1, 0, 0, 0, "R10 xor");
    step(INC, 3, 0, 0, 0, 0, 0, 1, 0, 0, "R9 reversed output");
    step(INC, 3, 0, 0, 0, 0, 0, 0, 0, 0, "R9 writeback unreversed");
    step(NOP, 0, 0, 0, 0, 0, 0, 0, 0, 0, "R10 idle flag low");
    step(LDC, 0, 0, 2, 0, 16'h0010, 0, 0, 0, 0, "R11 load holds addr");
    step(ADD, 1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 code3 left offset0 intact");
    step(SHL, 1, 0, 0, 0, 0, 0, 1, 0, 0, "R9 reversed shift");
    repeat (3) @(negedge clk);
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule